// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models the status side of a 32-bit flash array made of four byte lanes. A command port accepts program, sector erase, erase suspend, erase resume and identification-mode requests. Each request carries an address, a data word and a protection flag, and takes effect on the clock edge where `cmd_valid` is high. That edge stands for the rising edge of the last write strobe of a command sequence. While an embedded operation runs, reads return a polling word. In that word, bit 7 of every byte lane tells the host whether the operation is still in progress. When no operation is running, reads return the contents of a small on-chip array.

Operation times are given as clock-cycle parameters:

- a normal program,
- a normal erase,
- the short busy window for a program aimed at a protected sector,
- the longer busy window for an erase whose selected sectors are all protected.

An erase can be suspended. While it is suspended, the host may program other words or enter identification mode. Leaving identification mode returns the block to the suspended state. A resume continues the erase from where it stopped.

Top module: `fstat_top`

## Requirements
- R1: After reset every array word reads 32'hFFFF_FFFF and `busy` is 0.
- R2: Command code 1 writes the new word as the bitwise AND of the old word and `cmd_data` at `cmd_addr` when `cmd_prot` is 0. For PROG_CYC cycles after the accepting edge, `busy` is 1. During those cycles, bits 7, 15, 23 and 31 of `rd_data` read as the inverse of the same bits of `cmd_data`. After that window the array contents are returned.
- R3: Command code 2 erases sectors. `cmd_data[3:0]` selects the sectors, and the sector of a word is `addr[3:2]`. While the erase runs, bits 7, 15, 23 and 31 of `rd_data` read 0 and `busy` is 1, for ERASE_CYC cycles of erasing in total. When it completes, every word of each erased sector reads 32'hFFFF_FFFF and all other words are unchanged.
- R4: `cmd_data[7:4]` marks protected sectors for an erase. Only sectors that are selected and not protected are erased.
- R5: A program with `cmd_prot` 1 shows the inverse-bit polling word with `busy` 1 for PROT_PROG_CYC cycles. It then returns to array read and leaves the array unchanged.
- R6: An erase whose selected sectors are all protected shows polling bits of 0 with `busy` 1 for PROT_ERASE_CYC cycles. It then returns to array read and leaves the array unchanged.
- R7: Command code 3 during an erase suspends it. While suspended:
  - `busy` is 0;
  - bits 7, 15, 23 and 31 read 1 at addresses in the erasing sectors;
  - other addresses read array data;
  - the erase makes no progress.
- R8: Command code 4 in the suspended state resumes the erase for its remaining cycles. A resume given while erasing is ignored. A new suspend after a resume is accepted.
- R9: A program accepted while suspended uses the inverse-bit polling of R2. After PROG_CYC cycles it returns to the suspended state, not to array read.
- R10: Command code 5 enters identification mode, where every read returns ID_WORD. Command code 6 leaves it, returning to array read, or to the suspended state if it was entered from there.
- R11: Codes 0 and 7 do nothing. A command not listed for the current state is ignored: no state change and no array change. In particular, a program sent during an erase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command accepted on this clock edge |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_W | Word address for program |
| cmd_data | input | 32 | Program data, or erase select/protect masks |
| cmd_prot | input | 1 | Program target is protected |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Array data, polling word or identification word |
| busy | output | 1 | Embedded operation in progress |

## Verification
The hardest situation to reach is a single erase that passes through several states before it finishes:

1. suspend,
2. a program inside the suspension,
3. an identification-mode round trip,
4. a repeated resume,
5. a second suspend.

The bench has to show that the erase's own progress freezes throughout. It starts one erase and steps it through that whole chain with directed commands, spaced a few cycles apart. A free-running counter of busy cycles then shows that the total equals the erase time plus the embedded program time. That total holds no matter how the erase was split.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
  localparam int DATA_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_SUSP   = 3'd3,
    OP_RESUME = 3'd4,
    OP_ID_IN  = 3'd5,
    OP_ID_OUT = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_SUSP  = 3'd3,
    ST_ID    = 3'd4
  } st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Top bit of every byte lane, gathered.
  function automatic logic [LANES-1:0] lane_tops(input logic [DATA_W-1:0] w);
    logic [LANES-1:0] r;
    for (int i = 0; i < LANES; i++) r[i] = w[i*LANE_W + LANE_W - 1];
    return r;
  endfunction

  // Replace the top bit of every byte lane.
  function automatic logic [DATA_W-1:0] put_tops(input logic [DATA_W-1:0] w,
                                                 input logic [LANES-1:0] t);
    logic [DATA_W-1:0] r;
    r = w;
    for (int i = 0; i < LANES; i++) r[i*LANE_W + LANE_W - 1] = t[i];
    return r;
  endfunction
endpackage

// File: rtl/fstat_seq.sv
module fstat_seq
  import fstat_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int SECT_BITS      = 2,
  parameter int PROG_CYC       = 6,
  parameter int ERASE_CYC      = 20,
  parameter int PROT_PROG_CYC  = 3,
  parameter int PROT_ERASE_CYC = 10,
  localparam int NSECT = 1 << SECT_BITS,
  localparam int CNT_W = $clog2(max2(max2(PROG_CYC, ERASE_CYC),
                                     max2(PROT_PROG_CYC, PROT_ERASE_CYC)) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_prot,
  output st_e               st,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [NSECT-1:0]  erase_set,
  output logic [CNT_W-1:0]  er_cnt,
  output logic              wr_prog,
  output logic              wr_erase
);
  logic [CNT_W-1:0] op_cnt;
  logic             prog_guard;
  logic             prog_in_susp;
  logic             erase_dummy;
  logic             id_ret_susp;
  logic [NSECT-1:0] new_mask;

  assign new_mask = cmd_data[NSECT-1:0] & ~cmd_data[2*NSECT-1 -: NSECT];
  assign wr_prog  = (st == ST_PROG) && (op_cnt == '0) && !prog_guard;
  assign wr_erase = (st == ST_ERASE) && (er_cnt == '0) && !erase_dummy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_READ;
      op_cnt       <= '0;
      er_cnt       <= '0;
      prog_addr    <= '0;
      prog_data    <= '0;
      prog_guard   <= 1'b0;
      prog_in_susp <= 1'b0;
      erase_set    <= '0;
      erase_dummy  <= 1'b0;
      id_ret_susp  <= 1'b0;
    end else begin
      case (st)
        ST_READ: if (cmd_valid) begin
          if (cmd_op == OP_PROG) begin
            st           <= ST_PROG;
            prog_addr    <= cmd_addr;
            prog_data    <= cmd_data;
            prog_guard   <= cmd_prot;
            prog_in_susp <= 1'b0;
            op_cnt       <= cmd_prot ? CNT_W'(PROT_PROG_CYC - 1) : CNT_W'(PROG_CYC - 1);
          end else if (cmd_op == OP_ERASE) begin
            st          <= ST_ERASE;
            erase_set   <= new_mask;
            erase_dummy <= (new_mask == '0);
            er_cnt      <= (new_mask == '0) ? CNT_W'(PROT_ERASE_CYC - 1)
                                            : CNT_W'(ERASE_CYC - 1);
          end else if (cmd_op == OP_ID_IN) begin
            st          <= ST_ID;
            id_ret_susp <= 1'b0;
          end
        end
        ST_PROG: begin
          if (op_cnt == '0) st <= prog_in_susp ? ST_SUSP : ST_READ;
          else              op_cnt <= op_cnt - 1'b1;
        end
        ST_ERASE: begin
          if (er_cnt == '0) begin
            st        <= ST_READ;
            erase_set <= '0;
          end else begin
            er_cnt <= er_cnt - 1'b1;
            if (cmd_valid && cmd_op == OP_SUSP && !erase_dummy) st <= ST_SUSP;
          end
        end
        ST_SUSP: if (cmd_valid) begin
          if (cmd_op == OP_RESUME) begin
            st <= ST_ERASE;
          end else if (cmd_op == OP_PROG) begin
            st           <= ST_PROG;
            prog_addr    <= cmd_addr;
            prog_data    <= cmd_data;
            prog_guard   <= cmd_prot;
            prog_in_susp <= 1'b1;
            op_cnt       <= cmd_prot ? CNT_W'(PROT_PROG_CYC - 1) : CNT_W'(PROG_CYC - 1);
          end else if (cmd_op == OP_ID_IN) begin
            st          <= ST_ID;
            id_ret_susp <= 1'b1;
          end
        end
        ST_ID: if (cmd_valid && cmd_op == OP_ID_OUT)
          st <= id_ret_susp ? ST_SUSP : ST_READ;
        default: st <= ST_READ;
      endcase
    end
  end
endmodule

// File: rtl/fstat_array.sv
module fstat_array
  import fstat_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int SECT_BITS = 2,
  localparam int NSECT     = 1 << SECT_BITS,
  localparam int DEPTH     = 1 << ADDR_W,
  localparam int WORD_BITS = ADDR_W - SECT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_prog,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              wr_erase,
  input  logic [NSECT-1:0]  erase_set,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam int SECT = i >> WORD_BITS;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '1;
      else if (wr_erase && erase_set[SECT])
        mem[i] <= '1;
      else if (wr_prog && prog_addr == ADDR_W'(i))
        mem[i] <= mem[i] & prog_data;
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/fstat_rdmux.sv
module fstat_rdmux
  import fstat_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int SECT_BITS = 2,
  parameter logic [DATA_W-1:0] ID_WORD = 32'hC3A5_0137,
  localparam int NSECT = 1 << SECT_BITS
) (
  input  st_e               st,
  input  logic [DATA_W-1:0] arr_word,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [NSECT-1:0]  erase_set,
  output logic [DATA_W-1:0] rd_data
);
  logic [LANES-1:0] tops;
  logic             in_erase_sect;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      case (st)
        ST_PROG:  tops[l] = ~prog_data[l*LANE_W + LANE_W - 1];
        ST_SUSP:  tops[l] = 1'b1;
        default:  tops[l] = 1'b0;
      endcase
    end
  end

  assign in_erase_sect = erase_set[rd_addr[ADDR_W-1 -: SECT_BITS]];

  always_comb begin
    case (st)
      ST_PROG, ST_ERASE: rd_data = put_tops(arr_word, tops);
      ST_SUSP:           rd_data = in_erase_sect ? put_tops(arr_word, tops) : arr_word;
      ST_ID:             rd_data = ID_WORD;
      default:           rd_data = arr_word;
    endcase
  end
endmodule

// File: rtl/fstat_top.sv
module fstat_top
  import fstat_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int SECT_BITS      = 2,
  parameter int PROG_CYC       = 6,
  parameter int ERASE_CYC      = 20,
  parameter int PROT_PROG_CYC  = 3,
  parameter int PROT_ERASE_CYC = 10,
  parameter logic [31:0] ID_WORD = 32'hC3A5_0137,
  localparam int NSECT = 1 << SECT_BITS,
  localparam int CNT_W = $clog2(max2(max2(PROG_CYC, ERASE_CYC),
                                     max2(PROT_PROG_CYC, PROT_ERASE_CYC)) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [31:0]       cmd_data,
  input  logic              cmd_prot,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              busy
);
  st_e               st;
  logic [ADDR_W-1:0] prog_addr;
  logic [31:0]       prog_data;
  logic [NSECT-1:0]  erase_set;
  logic [CNT_W-1:0]  er_cnt;
  logic              wr_prog;
  logic              wr_erase;
  logic [31:0]       arr_word;

  fstat_seq #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .PROT_PROG_CYC(PROT_PROG_CYC),
    .PROT_ERASE_CYC(PROT_ERASE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_prot(cmd_prot),
    .st(st), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_set(erase_set), .er_cnt(er_cnt), .wr_prog(wr_prog), .wr_erase(wr_erase)
  );

  fstat_array #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_prog(wr_prog), .prog_addr(prog_addr),
    .prog_data(prog_data), .wr_erase(wr_erase), .erase_set(erase_set),
    .rd_addr(rd_addr), .rd_word(arr_word)
  );

  fstat_rdmux #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .ID_WORD(ID_WORD)) u_rdmux (
    .st(st), .arr_word(arr_word), .rd_addr(rd_addr), .prog_data(prog_data),
    .erase_set(erase_set), .rd_data(rd_data)
  );

  assign busy = (st == ST_PROG) || (st == ST_ERASE);
endmodule

// File: rtl/fstat_chk.sv
module fstat_chk
  import fstat_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int SECT_BITS = 2,
  parameter int CNT_W     = 5,
  parameter logic [31:0] ID_WORD = 32'hC3A5_0137,
  localparam int NSECT = 1 << SECT_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input st_e               st,
  input logic              busy,
  input logic [31:0]       rd_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       prog_data,
  input logic [NSECT-1:0]  erase_set,
  input logic [CNT_W-1:0]  er_cnt,
  input logic              wr_erase
);
  assert_prog_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && cmd_valid && cmd_op == OP_PROG) |=> busy);

  assert_prog_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG) |-> lane_tops(rd_data) == ~lane_tops(prog_data));

  assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE) |-> lane_tops(rd_data) == '0);

  assert_dummy_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_erase |-> erase_set != '0);

  assert_susp_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP && erase_set[rd_addr[ADDR_W-1 -: SECT_BITS]]) |-> lane_tops(rd_data) == '1);

  assert_susp_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP) |=> (st != ST_ERASE && st != ST_READ) ? $stable(er_cnt) : 1'b1);

  assert_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP && cmd_valid && cmd_op == OP_RESUME) |=> st == ST_ERASE);

  assert_id_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ID) |-> rd_data == ID_WORD);
endmodule

bind fstat_top fstat_chk #(
  .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .CNT_W(CNT_W), .ID_WORD(ID_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .st(st),
  .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr), .prog_data(prog_data),
  .erase_set(erase_set), .er_cnt(er_cnt), .wr_erase(wr_erase)
);

// File: tb/fstat_top_bench.sv
module fstat_top_bench;
  localparam int CLK_P      = 10;
  localparam int P_CYC      = 6;
  localparam int E_CYC      = 20;
  localparam int PP_CYC     = 3;
  localparam int PE_CYC     = 10;
  localparam logic [31:0] IDW  = 32'hC3A5_0137;
  localparam logic [31:0] TOPS = 32'h8080_8080;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_prot = 0;
  logic [2:0] cmd_op = 0;
  logic [3:0] cmd_addr = 0, rd_addr = 0;
  logic [31:0] cmd_data = 0;
  logic [31:0] rd_data;
  logic busy;
  int n_chk = 0, n_fail = 0, busy_cnt = 0;
  bit done = 0;

  fstat_top #(.PROG_CYC(P_CYC), .ERASE_CYC(E_CYC), .PROT_PROG_CYC(PP_CYC),
              .PROT_ERASE_CYC(PE_CYC), .ID_WORD(IDW)) u_fstat_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_prot(cmd_prot),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (busy) busy_cnt <= busy_cnt + 1;

  // program vectors: {addr, data, expected word afterwards}
  localparam logic [67:0] PVEC [5] = '{
    {4'd1,  32'h1234_5678, 32'h1234_5678},
    {4'd1,  32'hFF00_FF00, 32'h1200_5600},
    {4'd6,  32'h80FF_007F, 32'h80FF_007F},
    {4'd9,  32'h7F80_FF01, 32'h7F80_FF01},
    {4'd14, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [3:0] a,
                     input logic [31:0] d, input logic p);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_prot = p; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog got=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    rd(4'd0, v);  chk("R1 word0", v, 32'hFFFF_FFFF);
    rd(4'd15, v); chk("R1 word15", v, 32'hFFFF_FFFF);

    // R2 program vectors
    foreach (PVEC[k]) begin
      logic [3:0] a; logic [31:0] d, e;
      {a, d, e} = PVEC[k];
      rd_addr = a;
      cmd(3'd1, a, d, 1'b0);
      rd(a, v);
      chk("R2 busy first", {31'd0, busy}, 32'd1);
      chk("R2 poll first", v & TOPS, ~d & TOPS);
      repeat (P_CYC - 1) @(negedge clk);
      rd(a, v);
      chk("R2 poll last", v & TOPS, ~d & TOPS);
      @(negedge clk);
      rd(a, v);
      chk("R2 idle", {31'd0, busy}, 32'd0);
      chk("R2 data", v, e);
    end

    // R3 erase sector 0
    busy_cnt = 0;
    cmd(3'd2, 4'd0, 32'h0000_0001, 1'b0);
    rd(4'd1, v);
    chk("R3 poll zero", v & TOPS, 32'd0);
    wait_idle();
    chk("R3 duration", busy_cnt, E_CYC);
    rd(4'd1, v); chk("R3 erased", v, 32'hFFFF_FFFF);
    rd(4'd6, v); chk("R3 other kept", v, 32'h80FF_007F);

    // R4 partial protection: select 1,2 protect 1
    cmd(3'd2, 4'd0, 32'h0000_0026, 1'b0);
    wait_idle();
    rd(4'd6, v); chk("R4 protected kept", v, 32'h80FF_007F);
    rd(4'd9, v); chk("R4 unprotected erased", v, 32'hFFFF_FFFF);

    // R5 protected program
    busy_cnt = 0;
    cmd(3'd1, 4'd14, 32'h1234_5678, 1'b1);
    rd(4'd14, v);
    chk("R5 poll", v & TOPS, ~32'h1234_5678 & TOPS);
    wait_idle();
    chk("R5 duration", busy_cnt, PP_CYC);
    rd(4'd14, v); chk("R5 unchanged", v, 32'h0);

    // R6 all-protected erase
    busy_cnt = 0;
    cmd(3'd2, 4'd0, 32'h0000_0088, 1'b0);
    rd(4'd14, v);
    chk("R6 poll zero", v & TOPS, 32'd0);
    wait_idle();
    chk("R6 duration", busy_cnt, PE_CYC);
    rd(4'd14, v); chk("R6 unchanged", v, 32'h0);

    // R7..R10 erase of sector 3 split by suspend
    busy_cnt = 0;
    cmd(3'd2, 4'd0, 32'h0000_0008, 1'b0);
    repeat (3) @(negedge clk);
    cmd(3'd3, 4'd0, 32'h0, 1'b0);
    rd(4'd14, v);
    chk("R7 not busy", {31'd0, busy}, 32'd0);
    chk("R7 poll one", v & TOPS, TOPS);
    rd(4'd6, v); chk("R7 other sector", v, 32'h80FF_007F);
    c1 = busy_cnt;
    repeat (5) @(negedge clk);
    chk("R7 frozen", busy_cnt, c1);
    rd(4'd14, v); chk("R7 still suspended", v & TOPS, TOPS);

    cmd(3'd1, 4'd5, 32'h0F0F_0F0F, 1'b0);
    rd(4'd5, v);
    chk("R9 busy", {31'd0, busy}, 32'd1);
    chk("R9 poll", v & TOPS, TOPS);
    repeat (P_CYC) @(negedge clk);
    chk("R9 back idle", {31'd0, busy}, 32'd0);
    rd(4'd14, v); chk("R9 back to suspend", v & TOPS, TOPS);
    rd(4'd5, v);  chk("R9 data", v, 32'h0F0F_0F0F);

    cmd(3'd5, 4'd0, 32'h0, 1'b0);
    rd(4'd3, v); chk("R10 id in suspend", v, IDW);
    cmd(3'd6, 4'd0, 32'h0, 1'b0);
    rd(4'd14, v);
    chk("R10 exit to suspend busy", {31'd0, busy}, 32'd0);
    chk("R10 exit to suspend poll", v & TOPS, TOPS);

    cmd(3'd4, 4'd0, 32'h0, 1'b0);
    rd(4'd14, v);
    chk("R8 resumed busy", {31'd0, busy}, 32'd1);
    chk("R8 resumed poll", v & TOPS, 32'd0);
    cmd(3'd4, 4'd0, 32'h0, 1'b0);
    chk("R8 repeat resume", {31'd0, busy}, 32'd1);
    cmd(3'd3, 4'd0, 32'h0, 1'b0);
    chk("R8 second suspend", {31'd0, busy}, 32'd0);
    cmd(3'd4, 4'd0, 32'h0, 1'b0);
    wait_idle();
    chk("R8 total time", busy_cnt, E_CYC + P_CYC);
    rd(4'd14, v); chk("R8 erase done", v, 32'hFFFF_FFFF);

    // R10 identification from read mode
    cmd(3'd5, 4'd0, 32'h0, 1'b0);
    rd(4'd9, v); chk("R10 id", v, IDW);
    cmd(3'd6, 4'd0, 32'h0, 1'b0);
    rd(4'd5, v); chk("R10 exit to read", v, 32'h0F0F_0F0F);

    // R11 ignored commands
    cmd(3'd2, 4'd0, 32'h0000_0002, 1'b0);
    cmd(3'd1, 4'd1, 32'h0, 1'b0);
    wait_idle();
    rd(4'd1, v); chk("R11 program during erase", v, 32'hFFFF_FFFF);
    rd(4'd5, v); chk("R11 erase applied", v, 32'hFFFF_FFFF);
    cmd(3'd7, 4'd1, 32'h0, 1'b0);
    rd(4'd1, v);
    chk("R11 code7 busy", {31'd0, busy}, 32'd0);
    chk("R11 code7 data", v, 32'hFFFF_FFFF);
    cmd(3'd4, 4'd0, 32'h0, 1'b0);
    chk("R11 resume in read", {31'd0, busy}, 32'd0);
    cmd(3'd6, 4'd0, 32'h0, 1'b0);
    rd(4'd1, v); chk("R11 id exit in read", v, 32'hFFFF_FFFF);

    done = 1;
    summary();
    $finish;
  end
endmodule